// File: doc/BRIEF.md
# Crypto Engine Command Queue Front End

This block is the part of a block-cipher accelerator that software talks to. Software writes 32-bit command words into a memory-mapped queue. When the engine has been started, a dispatcher takes words from the queue one at a time. It decodes the opcode in the top four bits of each word and gathers the argument words that belong to that command. Once the command is complete, it offers the command to the cipher datapath over a valid/ready handshake. The cipher core and the data movement sit outside this block; the datapath side only has to accept commands.

The block keeps a record of which of its two key slots has been loaded. It refuses cipher operations that name an empty slot, and it rejects set-key commands whose fields it cannot honour. A barrier command lets software ask for a notification once everything queued before it has gone out. Unknown opcodes, queue overflow, empty-slot use, bad keys and barrier notifications each set their own status bit. Every status bit can be masked, and the unmasked bits are combined onto one interrupt line. Registers are reached through a simple single-cycle write strobe, with a read port that responds combinationally to the address.

Top module: `crypto_cmd_front`

## Requirements
- R1: After reset the queue is empty (queue status reads 0x00000002), the interrupt status is zero, `irq` and `cmdValid` are low, and neither key slot counts as loaded.
- R2: A write to offset 0x200 appends the word to the queue. The queue status register at 0x24 reads back as follows: write pointer in bits 31:24, read pointer in 23:16, fill level in 15:8, full in bit 2, empty in bit 1. Pointers wrap at the queue depth.
- R3: A queue write made while the queue is full is dropped: level, pointers and contents stay unchanged. The write also sets interrupt status bit 1.
- R4: Writing the control register at 0x08 acts on three bits. Bit 0 starts dispatch. Bit 1 stops it, and wins if written together with bit 0. Bit 2 zeroes both pointers and the level, and abandons a command whose arguments are still being gathered. The register reads as zero.
- R5: The opcode sits in bits 31:28, and the number of argument words depends on it:
  - Set key (1): when the source field [26:24] is 0, it takes 4, 6 or 8 words for length code [23:22] = 0, 1 or 2 (code 3 takes 8). A nonzero source takes none.
  - Set IV (2): 4 words.
  - Crypt (5): 2 words.
  - Get IV (6): none.

  A command is offered only once all its arguments have arrived, with the header on `cmdHeader`, bits 31:28 on `cmdOpcode`, the count on `cmdArgCount`, and argument i in `cmdArgs[32*i+31:32*i]`.
- R6: Any opcode other than 1, 2, 5, 6 and 8 sets interrupt status bit 2. The word is discarded, no argument words are consumed, and nothing is offered.
- R7: A barrier (opcode 8) is never offered. With bit 27 set, it sets status bit 5, but only after every earlier command has been accepted. With bit 27 clear, it has no effect.
- R8: A set key whose length code is 3, whose chaining mode [17:16] is 3, or whose source is above 3 is discarded after its argument words. It sets status bit 7 for slot 0 or bit 13 for slot 1, where the slot is bit 27, and it leaves the slot state unchanged. A valid set key marks its slot loaded when it is accepted.
- R9: A crypt whose key slot (bit 27) is not loaded is discarded after its two argument words. It sets status bit 11 for slot 0 or bit 17 for slot 1.
- R10: While `cmdValid` is high and `cmdReady` is low, `cmdValid` stays high and every command field stays unchanged.
- R11: The interrupt status at 0x18 is write-1-to-clear. The interrupt enable at 0x1C is read/write with the same layout, and it keeps only the defined bits 1, 2, 5, 7, 11, 13 and 17 (so writing all ones reads back 0x000228A6). `irq` is the OR of status ANDed with enable.
- R12: While dispatch is stopped, no word leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` |
| irq | output | 1 | Combined masked interrupt |
| cmdValid | output | 1 | Decoded command offered |
| cmdReady | input | 1 | Datapath accepts the command |
| cmdOpcode | output | 4 | Opcode of the offered command |
| cmdHeader | output | 32 | Full header word |
| cmdArgCount | output | 4 | Number of valid argument words |
| cmdArgs | output | 256 | Argument words, word 0 in the low bits |

## Verification
The bench builds the block with a queue depth of 8 rather than 64. This makes a full queue, an overflowing write and pointer wrap-around reachable within a handful of writes. It also means a software set-key of nine words cannot sit in the queue whole, so the dispatcher must consume words while the bench is still writing. A random ready pattern on the datapath side holds commands in the offered state, which exercises the hold rule and the ordering of barrier notifications against stalled commands.

// File: rtl/ccq_pkg.sv
package ccq_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_ARGS  = 8;
  localparam int ARG_IDX_W = $clog2(MAX_ARGS);
  localparam int ARG_CNT_W = $clog2(MAX_ARGS + 1);

  localparam logic [3:0] OP_SETKEY  = 4'd1;
  localparam logic [3:0] OP_SETIV   = 4'd2;
  localparam logic [3:0] OP_CRYPT   = 4'd5;
  localparam logic [3:0] OP_GETIV   = 4'd6;
  localparam logic [3:0] OP_BARRIER = 4'd8;

  localparam logic [11:0] OFF_CTRL  = 12'h008;
  localparam logic [11:0] OFF_IRQST = 12'h018;
  localparam logic [11:0] OFF_IRQEN = 12'h01C;
  localparam logic [11:0] OFF_QSTAT = 12'h024;
  localparam logic [11:0] OFF_QPORT = 12'h200;

  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_CLEAR = 2;

  localparam int IRQ_OVF      = 1;
  localparam int IRQ_UNKNOWN  = 2;
  localparam int IRQ_FLAG     = 5;
  localparam int IRQ_K0_BAD   = 7;
  localparam int IRQ_K0_EMPTY = 11;
  localparam int IRQ_K1_BAD   = 13;
  localparam int IRQ_K1_EMPTY = 17;
  localparam logic [WORD_W-1:0] IRQ_MASK =
    (WORD_W'(1) << IRQ_OVF) | (WORD_W'(1) << IRQ_UNKNOWN) | (WORD_W'(1) << IRQ_FLAG) |
    (WORD_W'(1) << IRQ_K0_BAD) | (WORD_W'(1) << IRQ_K0_EMPTY) |
    (WORD_W'(1) << IRQ_K1_BAD) | (WORD_W'(1) << IRQ_K1_EMPTY);

  typedef struct packed {
    logic                 push;
    logic                 pop;
    logic                 clear;
    logic                 hdrLoad;
    logic                 argLoad;
    logic [ARG_IDX_W-1:0] argIdx;
  } strobe_t;
endpackage

// File: rtl/ccq_datapath.sv
module ccq_datapath
  import ccq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [WORD_W-1:0]          wrData,
  output logic [WORD_W-1:0]          hdr,
  output logic [MAX_ARGS*WORD_W-1:0] args,
  output logic                       full,
  output logic                       empty,
  output logic [PTR_W:0]             level,
  output logic [PTR_W-1:0]           wPtr,
  output logic [PTR_W-1:0]           rPtr
);
  localparam int LVL_W = PTR_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] argRegs [MAX_ARGS];
  logic [WORD_W-1:0] headWord;

  assign headWord = mem[rPtr];
  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);

  always_ff @(posedge clk) begin
    if (stb.push) mem[wPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      level <= '0;
    end else if (stb.clear) begin
      wPtr  <= '0;
      rPtr  <= '0;
      level <= '0;
    end else begin
      if (stb.push) wPtr <= wPtr + PTR_W'(1);
      if (stb.pop)  rPtr <= rPtr + PTR_W'(1);
      level <= level + LVL_W'(stb.push) - LVL_W'(stb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hdr <= '0;
    else if (stb.hdrLoad) hdr <= headWord;
  end

  generate
    for (genvar i = 0; i < MAX_ARGS; i++) begin : g_arg
      always_ff @(posedge clk) begin
        if (!rstN) argRegs[i] <= '0;
        else if (stb.argLoad && (stb.argIdx == ARG_IDX_W'(i))) argRegs[i] <= headWord;
      end
      assign args[i*WORD_W +: WORD_W] = argRegs[i];
    end
  endgenerate
endmodule

// File: rtl/ccq_control.sv
module ccq_control
  import ccq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 qWrite,
  input  logic                 ctlWrite,
  input  logic                 stWrite,
  input  logic                 enWrite,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 fifoFull,
  input  logic                 fifoEmpty,
  input  logic [WORD_W-1:0]    hdr,
  input  logic                 cmdReady,
  output strobe_t              stb,
  output logic                 cmdValid,
  output logic [ARG_CNT_W-1:0] argCount,
  output logic [WORD_W-1:0]    irqStatus,
  output logic [WORD_W-1:0]    irqEnable,
  output logic                 running
);
  typedef enum logic [2:0] {S_IDLE, S_DEC, S_ARGS, S_CHK, S_ISSUE} state_t;

  state_t               state, nextState;
  logic [ARG_CNT_W-1:0] argIdxQ;
  logic [ARG_CNT_W-1:0] needArgs;
  logic [1:0]           keyLoaded;
  logic [WORD_W-1:0]    evt;
  logic [3:0]           op;
  logic                 slot, knownOp, keyBad, clearReq, canPop;
  logic [2:0]           keySrc;
  logic [1:0]           keyLen, chainMode;
  logic                 unusedHdrBits;

  assign op            = hdr[31:28];
  assign slot          = hdr[27];
  assign keySrc        = hdr[26:24];
  assign keyLen        = hdr[23:22];
  assign chainMode     = hdr[17:16];
  assign unusedHdrBits = ^{hdr[21], hdr[20:18], hdr[15:0]};

  assign knownOp  = (op == OP_SETKEY) || (op == OP_SETIV) || (op == OP_CRYPT) ||
                    (op == OP_GETIV) || (op == OP_BARRIER);
  assign keyBad   = (keyLen == 2'd3) || (chainMode == 2'd3) || (keySrc > 3'd3);
  assign clearReq = ctlWrite && wdata[CTL_CLEAR];
  assign canPop   = running && !fifoEmpty && !clearReq;
  assign argCount = needArgs;

  always_comb begin
    case (op)
      OP_SETKEY: begin
        if (keySrc != 3'd0)      needArgs = ARG_CNT_W'(0);
        else if (keyLen == 2'd0) needArgs = ARG_CNT_W'(4);
        else if (keyLen == 2'd1) needArgs = ARG_CNT_W'(6);
        else                     needArgs = ARG_CNT_W'(8);
      end
      OP_SETIV: needArgs = ARG_CNT_W'(4);
      OP_CRYPT: needArgs = ARG_CNT_W'(2);
      default:  needArgs = ARG_CNT_W'(0);
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.push  = qWrite && !fifoFull && !clearReq;
    stb.clear = clearReq;
    nextState = state;
    cmdValid  = 1'b0;
    evt       = '0;
    case (state)
      S_IDLE: begin
        if (canPop) begin
          stb.pop     = 1'b1;
          stb.hdrLoad = 1'b1;
          nextState   = S_DEC;
        end
      end
      S_DEC: begin
        if (!knownOp) begin
          evt[IRQ_UNKNOWN] = 1'b1;
          nextState        = S_IDLE;
        end else if (op == OP_BARRIER) begin
          evt[IRQ_FLAG] = slot;
          nextState     = S_IDLE;
        end else if (needArgs == '0) begin
          nextState = S_CHK;
        end else begin
          nextState = S_ARGS;
        end
      end
      S_ARGS: begin
        if (canPop) begin
          stb.pop     = 1'b1;
          stb.argLoad = 1'b1;
          stb.argIdx  = argIdxQ[ARG_IDX_W-1:0];
          if (argIdxQ == needArgs - ARG_CNT_W'(1)) nextState = S_CHK;
        end
      end
      S_CHK: begin
        nextState = S_ISSUE;
        if (op == OP_SETKEY && keyBad) begin
          evt[slot ? IRQ_K1_BAD : IRQ_K0_BAD] = 1'b1;
          nextState = S_IDLE;
        end else if (op == OP_CRYPT && !keyLoaded[slot]) begin
          evt[slot ? IRQ_K1_EMPTY : IRQ_K0_EMPTY] = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    if (clearReq && state != S_ISSUE) begin
      nextState = S_IDLE;
      evt       = '0;
    end
    evt[IRQ_OVF] = qWrite && fifoFull && !clearReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      argIdxQ   <= '0;
      keyLoaded <= '0;
      running   <= 1'b0;
      irqStatus <= '0;
      irqEnable <= '0;
    end else begin
      state <= nextState;
      if (state != S_ARGS)  argIdxQ <= '0;
      else if (stb.argLoad) argIdxQ <= argIdxQ + ARG_CNT_W'(1);
      if (state == S_ISSUE && cmdReady && op == OP_SETKEY) keyLoaded[slot] <= 1'b1;
      if (ctlWrite) begin
        if (wdata[CTL_STOP])       running <= 1'b0;
        else if (wdata[CTL_START]) running <= 1'b1;
      end
      irqStatus <= ((irqStatus & ~(stWrite ? wdata : '0)) | evt) & IRQ_MASK;
      if (enWrite) irqEnable <= wdata & IRQ_MASK;
    end
  end
endmodule

// File: rtl/crypto_cmd_front.sv
module crypto_cmd_front
  import ccq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [11:0]                busAddr,
  input  logic [WORD_W-1:0]          busWdata,
  output logic [WORD_W-1:0]          busRdata,
  output logic                       irq,
  output logic                       cmdValid,
  input  logic                       cmdReady,
  output logic [3:0]                 cmdOpcode,
  output logic [WORD_W-1:0]          cmdHeader,
  output logic [ARG_CNT_W-1:0]       cmdArgCount,
  output logic [MAX_ARGS*WORD_W-1:0] cmdArgs
);
  strobe_t           stb;
  logic              qWrite, ctlWrite, stWrite, enWrite;
  logic              fifoFull, fifoEmpty, running;
  logic [PTR_W:0]    fifoLevel;
  logic [PTR_W-1:0]  wPtr, rPtr;
  logic [WORD_W-1:0] irqStatus, irqEnable;

  assign qWrite   = busWe && (busAddr == OFF_QPORT);
  assign ctlWrite = busWe && (busAddr == OFF_CTRL);
  assign stWrite  = busWe && (busAddr == OFF_IRQST);
  assign enWrite  = busWe && (busAddr == OFF_IRQEN);

  ccq_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .hdr(cmdHeader), .args(cmdArgs), .full(fifoFull), .empty(fifoEmpty),
    .level(fifoLevel), .wPtr(wPtr), .rPtr(rPtr)
  );

  ccq_control uCtrl (
    .clk(clk), .rstN(rstN), .qWrite(qWrite), .ctlWrite(ctlWrite),
    .stWrite(stWrite), .enWrite(enWrite), .wdata(busWdata),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .hdr(cmdHeader),
    .cmdReady(cmdReady), .stb(stb), .cmdValid(cmdValid),
    .argCount(cmdArgCount), .irqStatus(irqStatus), .irqEnable(irqEnable),
    .running(running)
  );

  assign cmdOpcode = cmdHeader[31:28];
  assign irq       = |(irqStatus & irqEnable);

  always_comb begin
    case (busAddr)
      OFF_IRQST: busRdata = irqStatus;
      OFF_IRQEN: busRdata = irqEnable;
      OFF_QSTAT: busRdata = {8'(wPtr), 8'(rPtr), 8'(fifoLevel), 5'd0, fifoFull, fifoEmpty, 1'b0};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ccq_checker.sv
module ccq_checker #(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic         clk,
  input logic         rstN,
  input logic         qWrite,
  input logic         clearStb,
  input logic         fifoFull,
  input logic         fifoEmpty,
  input logic [PTR_W:0] fifoLevel,
  input logic [31:0]  irqStatus,
  input logic [31:0]  irqEnable,
  input logic         irq,
  input logic         cmdValid,
  input logic         cmdReady,
  input logic [31:0]  cmdHeader
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdHeader)); // R10
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    qWrite && fifoFull && !clearStb |=> irqStatus[1]); // R3
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty)); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= (PTR_W + 1)'(DEPTH)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> fifoEmpty); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqEnable == '0 |-> !irq); // R11
  AST_ONLY_KNOWN_ISSUED: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdHeader[31:28] == 4'd1 || cmdHeader[31:28] == 4'd2 ||
                  cmdHeader[31:28] == 4'd5 || cmdHeader[31:28] == 4'd6)); // R6
endmodule

bind crypto_cmd_front ccq_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .qWrite(qWrite), .clearStb(stb.clear),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel),
  .irqStatus(irqStatus), .irqEnable(irqEnable), .irq(irq),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdHeader(cmdHeader)
);

// File: tb/tb_crypto_cmd_front.sv
`timescale 1ns/1ps
module tb_crypto_cmd_front;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWe = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         irq, cmdValid;
  logic         cmdReady = 1'b0;
  logic [3:0]   cmdOpcode;
  logic [31:0]  cmdHeader;
  logic [3:0]   cmdArgCount;
  logic [255:0] cmdArgs;

  crypto_cmd_front #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOpcode(cmdOpcode), .cmdHeader(cmdHeader), .cmdArgCount(cmdArgCount),
    .cmdArgs(cmdArgs)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int readyMode = 2;
  bit done = 0;
  logic [31:0] expHdr [512];
  int          expCnt [512];
  logic [31:0] expArg [512][8];
  int expWr = 0, gotIdx = 0;
  logic [31:0] wordBuf [10];
  int nW;
  logic [31:0] expSt;
  bit [1:0] keyModel;
  logic [31:0] rv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busWe = 1'b0; busAddr = a; #1; d = busRdata;
  endtask

  task automatic pushAll();
    logic [31:0] s;
    for (int i = 0; i < nW; i++) begin
      do rd(12'h024, s); while (s[2]);
      wr(12'h200, wordBuf[i]);
    end
  endtask

  task automatic expectIssue(input int cnt);
    expHdr[expWr] = wordBuf[0];
    expCnt[expWr] = cnt;
    for (int i = 0; i < cnt; i++) expArg[expWr][i] = wordBuf[i+1];
    expWr++;
  endtask

  task automatic drain();
    logic [31:0] s;
    readyMode = 2;
    do rd(12'h024, s); while (!s[1]);
    repeat (30) @(negedge clk);
  endtask

  function automatic int keyArgs(input logic [31:0] h);
    if (h[26:24] != 3'd0) return 0;
    case (h[23:22]) 2'd0: return 4; 2'd1: return 6; default: return 8; endcase
  endfunction

  task automatic genRandom();
    logic [31:0] r;
    int kind, n;
    r = $urandom();
    kind = $urandom_range(0, 9);
    case (kind)
      0, 1: begin
        int sel;
        sel = $urandom_range(0, 5);
        wordBuf[0] = {4'd1, r[27:0]};
        wordBuf[0][26:24] = (sel < 4) ? 3'd0 : (sel == 4) ? 3'($urandom_range(1, 3)) : 3'($urandom_range(4, 7));
        n = keyArgs(wordBuf[0]);
        if (wordBuf[0][23:22] == 2'd3 || wordBuf[0][17:16] == 2'd3 || wordBuf[0][26:24] > 3'd3)
          expSt[wordBuf[0][27] ? 13 : 7] = 1'b1;
        else begin
          for (int i = 0; i < n; i++) wordBuf[i+1] = $urandom();
          expectIssue(n);
          keyModel[wordBuf[0][27]] = 1'b1;
        end
      end
      2: begin wordBuf[0] = {4'd2, r[27:0]}; n = 4; end
      3, 4: begin
        wordBuf[0] = {4'd5, r[27:0]}; n = 2;
        if (!keyModel[wordBuf[0][27]]) expSt[wordBuf[0][27] ? 17 : 11] = 1'b1;
      end
      5: begin wordBuf[0] = {4'd6, r[27:0]}; n = 0; end
      6, 7: begin
        wordBuf[0] = {4'd8, r[27:0]}; n = 0;
        if (r[27]) expSt[5] = 1'b1;
      end
      default: begin
        int op;
        do op = $urandom_range(0, 15); while (op == 1 || op == 2 || op == 5 || op == 6 || op == 8);
        wordBuf[0] = {4'(op), r[27:0]}; n = 0;
        expSt[2] = 1'b1;
      end
    endcase
    for (int i = 0; i < n; i++) wordBuf[i+1] = $urandom();
    if (kind == 0 || kind == 1) begin
      if (expWr > 0 && expHdr[expWr-1] === wordBuf[0])
        for (int i = 0; i < n; i++) expArg[expWr-1][i] = wordBuf[i+1];
    end else if (kind == 2 || kind == 5 ||
                 ((kind == 3 || kind == 4) && keyModel[wordBuf[0][27]])) begin
      expectIssue(n);
    end
    nW = n + 1;
  endtask

  always @(negedge clk) begin
    case (readyMode)
      0: cmdReady = ($urandom_range(0, 3) != 0);
      1: cmdReady = 1'b0;
      default: cmdReady = 1'b1;
    endcase
    if (rstN && cmdValid && cmdReady) begin
      if (gotIdx >= expWr) begin
        checks++; errors++;
        $display("FAIL R5 unexpected command actual=%h expected=none", cmdHeader);
      end else begin
        chk("R5 header", cmdHeader, expHdr[gotIdx]);
        chk("R5 opcode", 32'(cmdOpcode), 32'(expHdr[gotIdx][31:28]));
        chk("R5 arg count", 32'(cmdArgCount), 32'(expCnt[gotIdx]));
        for (int i = 0; i < expCnt[gotIdx]; i++)
          chk($sformatf("R5 arg %0d", i), cmdArgs[32*i +: 32], expArg[gotIdx][i]);
        gotIdx++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    expSt = '0; keyModel = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(12'h024, rv); chk("R1 queue status", rv, 32'h0000_0002);
    rd(12'h018, rv); chk("R1 irq status", rv, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 cmdValid", 32'(cmdValid), 32'h0);
    // R12 / R2 stopped engine keeps words
    for (int i = 0; i < 3; i++) wr(12'h200, 32'h6000_0000 + i);
    repeat (10) @(negedge clk);
    rd(12'h024, rv); chk("R12 R2 level while stopped", rv, 32'h0300_0300);
    chk("R12 no issue while stopped", 32'(cmdValid), 32'h0);
    // R2 fill and wrap, R3 overflow
    for (int i = 0; i < 5; i++) wr(12'h200, 32'h6000_0010 + i);
    rd(12'h024, rv); chk("R2 full wrap", rv, 32'h0000_0804);
    wr(12'h200, 32'hDEAD_BEEF);
    rd(12'h024, rv); chk("R3 level unchanged", rv, 32'h0000_0804);
    rd(12'h018, rv); chk("R3 overflow bit", rv, 32'h0000_0002);
    rd(12'h008, rv); chk("R4 control reads zero", rv, 32'h0);
    // R4 clear, R11 W1C and enable mask
    wr(12'h008, 32'h4);
    rd(12'h024, rv); chk("R4 clear", rv, 32'h0000_0002);
    wr(12'h018, 32'h2);
    rd(12'h018, rv); chk("R11 w1c", rv, 32'h0);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, rv); chk("R11 enable mask", rv, 32'h0002_28A6);
    wr(12'h01C, 32'h0);
    // R6 unknown, R9 empty slot
    wr(12'h008, 32'h1);
    nW = 4; wordBuf[0] = 32'h0000_0000; wordBuf[1] = 32'h5800_0010;
    wordBuf[2] = 32'h1111_1111; wordBuf[3] = 32'h2222_2222;
    pushAll(); drain();
    rd(12'h018, rv); chk("R6 R9 unknown and slot1 empty", rv, 32'h0002_0004);
    wr(12'h01C, 32'h0002_0000); chk("R11 irq enabled bit", 32'(irq), 32'h1);
    wr(12'h01C, 32'h0000_0020); chk("R11 irq masked", 32'(irq), 32'h0);
    wr(12'h018, 32'hFFFF_FFFF); wr(12'h01C, 32'h0);
    // R7 barrier after stalled command, R10 hold
    readyMode = 1;
    nW = 1; wordBuf[0] = 32'h6000_00AB; expectIssue(0); pushAll();
    nW = 1; wordBuf[0] = 32'h8800_0000; pushAll();
    repeat (20) @(negedge clk);
    chk("R10 held valid", 32'(cmdValid), 32'h1);
    chk("R10 held header", cmdHeader, 32'h6000_00AB);
    rd(12'h018, rv); chk("R7 flag waits", rv, 32'h0);
    drain();
    rd(12'h018, rv); chk("R7 flag after drain", rv, 32'h0000_0020);
    wr(12'h018, 32'hFFFF_FFFF);
    nW = 1; wordBuf[0] = 32'h8000_0000; pushAll(); drain();
    rd(12'h018, rv); chk("R7 barrier without flag", rv, 32'h0);
    // R8 key slots
    nW = 1; wordBuf[0] = 32'h1100_0000; expectIssue(0); pushAll();
    keyModel[0] = 1'b1;
    nW = 3; wordBuf[0] = 32'h5000_0020; wordBuf[1] = 32'hA5A5_0001; wordBuf[2] = 32'hA5A5_0002;
    expectIssue(2); pushAll();
    nW = 9; wordBuf[0] = 32'h18C0_0000;
    for (int i = 1; i < 9; i++) wordBuf[i] = 32'hC0DE_0000 + i;
    pushAll();
    nW = 3; wordBuf[0] = 32'h5800_0004; wordBuf[1] = 32'h1; wordBuf[2] = 32'h2; pushAll();
    drain();
    rd(12'h018, rv); chk("R8 R9 bad key and slot1 still empty", rv, 32'h0002_2000);
    wr(12'h018, 32'hFFFF_FFFF);
    // R4 clear abandons partial command
    wr(12'h008, 32'h2);
    nW = 2; wordBuf[0] = 32'h2000_0000; wordBuf[1] = 32'h1234_5678; pushAll();
    wr(12'h008, 32'h1);
    repeat (10) @(negedge clk);
    wr(12'h008, 32'h4);
    nW = 1; wordBuf[0] = 32'h6000_0777; expectIssue(0); pushAll();
    drain();
    chk("R4 only get IV after clear", 32'(gotIdx), 32'(expWr));
    // random phase
    readyMode = 0;
    for (int c = 0; c < 150; c++) begin
      genRandom();
      readyMode = 0;
      pushAll();
    end
    drain();
    chk("R5 issued count", 32'(gotIdx), 32'(expWr));
    rd(12'h018, rv); chk("R6 R7 R8 R9 random status", rv, expSt);
    wr(12'h01C, expSt);
    chk("R11 irq random", 32'(irq), 32'(expSt != 0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule